// File: doc/BRIEF.md
# Flash Command Interface Controller

This controller sits between a host bus and a parallel NOR memory array of 256K sixteen-bit words. The host writes command bytes on the low eight bits of the write data. The controller decodes them into reads of the array, the manufacturer and device identifiers, or its status word. It also runs two-cycle block erase and word program operations through an internal sequencer. Each operation first spends a parameterised number of cycles in a timing phase, then issues one request to the array and waits for the array's done pulse.

An erase or program can be suspended while it is in its timing phase, and later resumed from the cycle where it stopped. While an erase is suspended, only the status-read and resume commands are honoured. While a program is suspended, the host may also read the array or the identifiers. A write-protect input guards the two topmost 4K-word boot blocks. With the input low, an operation aimed at them is refused and an error bit is raised, and the array is never touched.

The host issues one read at a time and waits for `host_rvalid` before issuing the next read or write. A read gets its data on `host_rdata` one cycle after the strobe when it comes from status or identifier. When it comes from the array, the data arrives one cycle after the array's done pulse.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in array-read mode: `ready_n_busy` is 1, no array request is raised, a host read is served through an array read request (`arr_cmd` 0), and the status word reads 0x0080.
- R2: Command FFh selects array-read mode. Later host reads return the array word at the host address.
- R3: Command 20h followed by D0h erases the block containing the confirm address. The erase request (`arr_cmd` 2) carries the block's first address. Blocks are 4K words in the top 32K words of the map and 32K words below it. With a one-cycle array, the controller is busy for ERASE_CYCLES+2 cycles.
- R4: Command 40h or 10h, followed by a data write, programs that data at the write address through a request with `arr_cmd` 1. The controller is busy for PROG_CYCLES+2 cycles.
- R5: While an operation runs, `ready_n_busy` is 0, status bit 7 is 0, and every host read returns the status word.
- R6: Command B0h during the timing phase suspends the operation. `ready_n_busy` and status bit 7 return to 1, and bit 6 (erase) or bit 2 (program) is set. No array write or erase is issued while the operation is suspended.
- R7: Command D0h while suspended clears the suspend bit, drives status bit 7 and `ready_n_busy` low, and lets the operation finish with its original effect.
- R8: While an erase is suspended, every command other than 70h and D0h is ignored, and reads keep returning the status word.
- R9: While a program is suspended, FFh gives array reads.
- R10: With `wp_n` low, an erase or program whose address has bits 17..13 all ones issues no array request, stays ready, and sets status bit 5 (erase) or bit 4 (program). With `wp_n` high, or for any other block, the operation proceeds.
- R11: After command 90h, a read at address 0 returns MFR_CODE and a read at address 1 returns DEV_CODE.
- R12: A second cycle after 20h that is not D0h sets status bits 5 and 4, starts nothing, and leaves status-read mode selected.
- R13: Status bits 5 and 4 stay set through later successful operations until command 50h clears them. Command 70h selects status-read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wp_n | input | 1 | Boot-block write protect, low locks the top two blocks |
| host_addr | input | ADDR_W | Word address for reads and writes |
| host_wdata | input | DATA_W | Command byte (bits 7..0) or program data |
| host_we | input | 1 | Write strobe, one cycle |
| host_re | input | 1 | Read strobe, one cycle |
| host_rdata | output | DATA_W | Read data |
| host_rvalid | output | 1 | One-cycle pulse marking valid read data |
| ready_n_busy | output | 1 | 1 when ready or suspended, 0 while an operation runs |
| arr_req | output | 1 | Array request, held until done |
| arr_cmd | output | 2 | 0 read, 1 program, 2 erase block |
| arr_addr | output | ADDR_W | Array word address or block base |
| arr_wdata | output | DATA_W | Program data |
| arr_done | input | 1 | One-cycle completion from the array |
| arr_rdata | input | DATA_W | Array read data, valid with done |

## Verification
The hardest case to reach is a suspended operation. The suspend command must land inside the timing phase, and then the controller must be proven to hold still while the host tries commands that should be refused. The bench shortens the timing counts and counts clock edges from the confirm write, so that the suspend arrives a known number of cycles into the phase. It then attempts array-read and identifier commands, watches that no array write or erase request appears for tens of cycles, and resumes. The final array contents show whether the operation finished exactly once and on the right block.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int ERASE_CYCLES = 64,
  parameter int PROG_CYCLES  = 8,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h00C3,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h5E21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_we,
  input  logic              host_re,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              ready_n_busy,
  output logic              arr_req,
  output logic [1:0]        arr_cmd,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata,
  input  logic              arr_done,
  input  logic [DATA_W-1:0] arr_rdata
);
  localparam int SML_W  = ADDR_W - 6;
  localparam int BIG_W  = ADDR_W - 3;
  localparam int MAXCYC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CNT_W  = $clog2(MAXCYC) + 1;

  typedef enum logic [1:0] {OP_IDLE, OP_RUN, OP_ARR, OP_SUSP} op_t;
  typedef enum logic [1:0] {M_ARRAY, M_STATUS, M_ID} mode_t;
  typedef enum logic [1:0] {P_NONE, P_ERASE, P_PROG} pend_t;

  op_t   op_st;
  mode_t mode;
  pend_t pend;
  logic [CNT_W-1:0]  cnt;
  logic              op_erase;
  logic [ADDR_W-1:0] op_addr, rd_addr;
  logic [DATA_W-1:0] op_data;
  logic              rd_pend;
  logic              esus, psus, eerr, perr;

  wire [7:0] cmd   = host_wdata[7:0];
  wire       ready = (op_st == OP_IDLE) || (op_st == OP_SUSP);
  wire [DATA_W-1:0] sr_word = {{(DATA_W-8){1'b0}}, ready, esus, eerr, perr, 1'b0, psus, 2'b00};

  function automatic logic [ADDR_W-1:0] base_of(input logic [ADDR_W-1:0] a);
    if (a[ADDR_W-1 -: 3] == 3'b111) return {a[ADDR_W-1:SML_W], {SML_W{1'b0}}};
    return {a[ADDR_W-1:BIG_W], {BIG_W{1'b0}}};
  endfunction

  function automatic logic locked(input logic [ADDR_W-1:0] a, input logic wp);
    return (a[ADDR_W-1 -: 5] == 5'b11111) && !wp;
  endfunction

  assign ready_n_busy = ready;
  assign arr_req   = (op_st == OP_ARR) || rd_pend;
  assign arr_cmd   = (op_st == OP_ARR) ? (op_erase ? 2'd2 : 2'd1) : 2'd0;
  assign arr_addr  = (op_st == OP_ARR) ? op_addr : rd_addr;
  assign arr_wdata = op_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_st <= OP_IDLE;  mode <= M_ARRAY;  pend <= P_NONE;
      cnt <= '0;  op_erase <= 1'b0;  op_addr <= '0;  op_data <= '0;
      rd_addr <= '0;  rd_pend <= 1'b0;  host_rvalid <= 1'b0;  host_rdata <= '0;
      esus <= 1'b0;  psus <= 1'b0;  eerr <= 1'b0;  perr <= 1'b0;
    end else begin
      host_rvalid <= 1'b0;

      case (op_st)
        OP_RUN:  if (cnt == '0) op_st <= OP_ARR; else cnt <= cnt - 1'b1;
        OP_ARR:  if (arr_done) op_st <= OP_IDLE;
        default: ;
      endcase

      if (rd_pend && arr_done) begin
        rd_pend     <= 1'b0;
        host_rvalid <= 1'b1;
        host_rdata  <= arr_rdata;
      end

      if (host_re && !rd_pend) begin
        if (!ready || mode == M_STATUS) begin
          host_rvalid <= 1'b1;
          host_rdata  <= sr_word;
        end else if (mode == M_ID) begin
          host_rvalid <= 1'b1;
          host_rdata  <= (host_addr == ADDR_W'(0)) ? MFR_CODE :
                         (host_addr == ADDR_W'(1)) ? DEV_CODE : '0;
        end else begin
          rd_pend <= 1'b1;
          rd_addr <= host_addr;
        end
      end

      if (host_we) begin
        if (pend == P_ERASE) begin
          pend <= P_NONE;
          mode <= M_STATUS;
          if (cmd != 8'hD0) begin
            eerr <= 1'b1;
            perr <= 1'b1;
          end else if (locked(host_addr, wp_n)) begin
            eerr <= 1'b1;
          end else begin
            op_st    <= OP_RUN;
            op_erase <= 1'b1;
            op_addr  <= base_of(host_addr);
            cnt      <= CNT_W'(ERASE_CYCLES - 1);
          end
        end else if (pend == P_PROG) begin
          pend <= P_NONE;
          mode <= M_STATUS;
          if (locked(host_addr, wp_n)) begin
            perr <= 1'b1;
          end else begin
            op_st    <= OP_RUN;
            op_erase <= 1'b0;
            op_addr  <= host_addr;
            op_data  <= host_wdata;
            cnt      <= CNT_W'(PROG_CYCLES - 1);
          end
        end else begin
          case (op_st)
            OP_RUN: begin
              if (cmd == 8'hB0) begin
                op_st <= OP_SUSP;
                cnt   <= cnt;
                mode  <= M_STATUS;
                if (op_erase) esus <= 1'b1; else psus <= 1'b1;
              end else if (cmd == 8'h70) begin
                mode <= M_STATUS;
              end
            end
            OP_SUSP: begin
              if (cmd == 8'hD0) begin
                op_st <= OP_RUN;
                esus  <= 1'b0;
                psus  <= 1'b0;
                mode  <= M_STATUS;
              end else if (cmd == 8'h70) begin
                mode <= M_STATUS;
              end else if (!op_erase && cmd == 8'hFF) begin
                mode <= M_ARRAY;
              end else if (!op_erase && cmd == 8'h90) begin
                mode <= M_ID;
              end
            end
            OP_IDLE: begin
              case (cmd)
                8'hFF:        mode <= M_ARRAY;
                8'h70:        mode <= M_STATUS;
                8'h90:        mode <= M_ID;
                8'h50:        begin eerr <= 1'b0; perr <= 1'b0; end
                8'h20:        pend <= P_ERASE;
                8'h40, 8'h10: pend <= P_PROG;
                default: ;
              endcase
            end
            default: ;
          endcase
        end
      end
    end
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    arr_req && !arr_done |=> arr_req);

  p_susp_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (op_st == OP_SUSP) && ($past(op_st) == OP_SUSP) |-> $stable(cnt));

  p_one_susp_r6: assert property (@(posedge clk) disable iff (rst)
    !(esus && psus));

  p_resume_busy_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(esus) || $fell(psus)) |-> !ready_n_busy);

  p_lock_r10: assert property (@(posedge clk) disable iff (rst)
    (op_st == OP_RUN) && ($past(op_st) == OP_IDLE) |->
      !(($past(wp_n) == 1'b0) && (op_addr[ADDR_W-1 -: 5] == 5'b11111)));

  p_err_clear_r13: assert property (@(posedge clk) disable iff (rst)
    $fell(eerr) |-> $past(host_we && host_wdata[7:0] == 8'h50 && op_st == OP_IDLE && pend == P_NONE));
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int DW = 16;
  localparam int EC = 20;
  localparam int PC = 6;
  localparam logic [DW-1:0] MFR = 16'h00C3;
  localparam logic [DW-1:0] DEV = 16'h5E21;

  logic clk = 0, rst = 1, wp_n = 1;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic host_we = 0, host_re = 0;
  logic [DW-1:0] host_rdata;
  logic host_rvalid, ready_n_busy, arr_req;
  logic [1:0] arr_cmd;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_wdata;
  logic arr_done = 0;
  logic [DW-1:0] arr_rdata = '0;

  int checks = 0, fails = 0, mod_ops = 0, rd_ops = 0;
  bit done_flag = 0;
  logic [DW-1:0] mem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .ERASE_CYCLES(EC), .PROG_CYCLES(PC),
                   .MFR_CODE(MFR), .DEV_CODE(DEV)) u_dut (
    .clk(clk), .rst(rst), .wp_n(wp_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_re(host_re), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .ready_n_busy(ready_n_busy), .arr_req(arr_req), .arr_cmd(arr_cmd), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_done(arr_done), .arr_rdata(arr_rdata));

  function automatic int blk_size(input int a);
    return (a >= 'h38000) ? 'h1000 : 'h8000;
  endfunction

  always @(posedge clk) begin
    arr_done <= 1'b0;
    if (arr_req && !arr_done) begin
      arr_done <= 1'b1;
      if (arr_cmd == 2'd0) begin
        rd_ops++;
        arr_rdata <= mem.exists(int'(arr_addr)) ? mem[int'(arr_addr)] : 16'hFFFF;
      end else if (arr_cmd == 2'd1) begin
        mod_ops++;
        mem[int'(arr_addr)] = (mem.exists(int'(arr_addr)) ? mem[int'(arr_addr)] : 16'hFFFF) & arr_wdata;
      end else begin
        int lo, hi;
        int kill[$];
        mod_ops++;
        lo = int'(arr_addr);
        hi = lo + blk_size(lo);
        foreach (mem[k]) if (k >= lo && k < hi) kill.push_back(k);
        foreach (kill[i]) mem.delete(kill[i]);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    host_addr = a; host_re = 1;
    @(negedge clk);
    host_re = 0;
    d = 'x;
    for (int i = 0; i < 20; i++) begin
      if (host_rvalid) begin d = host_rdata; break; end
      @(negedge clk);
    end
  endtask

  task automatic status(output logic [DW-1:0] d);
    wr(0, 16'h0070);
    rd(0, d);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!ready_n_busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 1000 && !ready_n_busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    int r0;
    chk("R1 ready after reset", ready_n_busy, 1);
    chk("R1 no request after reset", arr_req, 0);
    r0 = rd_ops;
    rd(5, d);
    chk("R1 array read data", d, 16'hFFFF);
    chk("R1 read went to array", rd_ops - r0, 1);
    status(d);
    chk("R1 status after reset", d, 16'h0080);
  endtask

  task automatic t_ident();
    logic [DW-1:0] d;
    wr(0, 16'h0090);
    rd(0, d); chk("R11 manufacturer code", d, MFR);
    rd(1, d); chk("R11 device code", d, DEV);
  endtask

  task automatic t_program();
    logic [DW-1:0] d;
    int n;
    wr('h00100, 16'h0040);
    wr('h00100, 16'h1234);
    chk("R5 busy pin low", ready_n_busy, 0);
    busy_len(n);
    chk("R4 program busy length", n, PC + 2);
    wr('h00200, 16'h0010);
    wr('h00200, 16'hA55A);
    rd('h00000, d);
    chk("R5 read while busy gives status", d, 16'h0000);
    wait_ready();
    wr(0, 16'h00FF);
    rd('h00100, d); chk("R2 R4 programmed word via 40h", d, 16'h1234);
    rd('h00200, d); chk("R4 programmed word via 10h", d, 16'hA55A);
  endtask

  task automatic t_erase();
    logic [DW-1:0] d;
    int n;
    wr('h01000, 16'h0040); wr('h01000, 16'h1111); wait_ready();
    wr('h08000, 16'h0040); wr('h08000, 16'h2222); wait_ready();
    wr('h05555, 16'h0020); wr('h05555, 16'h00D0);
    busy_len(n);
    chk("R3 erase busy length", n, EC + 2);
    wr(0, 16'h00FF);
    rd('h01000, d); chk("R3 main block erased", d, 16'hFFFF);
    rd('h08000, d); chk("R3 next main block kept", d, 16'h2222);
    wr('h38000, 16'h0040); wr('h38000, 16'h3333); wait_ready();
    wr('h39000, 16'h0040); wr('h39000, 16'h4444); wait_ready();
    wr('h38ABC, 16'h0020); wr('h38ABC, 16'h00D0); wait_ready();
    wr(0, 16'h00FF);
    rd('h38000, d); chk("R3 parameter block erased", d, 16'hFFFF);
    rd('h39000, d); chk("R3 next parameter block kept", d, 16'h4444);
  endtask

  task automatic t_bad_confirm();
    logic [DW-1:0] d;
    int m0;
    m0 = mod_ops;
    wr('h02000, 16'h0020);
    wr('h02000, 16'h00AA);
    rd(0, d);
    chk("R12 bad confirm sets both errors", d, 16'h00B0);
    chk("R12 nothing started", mod_ops - m0, 0);
    wr('h00300, 16'h0040); wr('h00300, 16'h00F0); wait_ready();
    status(d);
    chk("R13 errors survive success", d, 16'h00B0);
    wr(0, 16'h0050);
    status(d);
    chk("R13 clear status", d, 16'h0080);
  endtask

  task automatic t_erase_susp();
    logic [DW-1:0] d;
    int m0;
    wr('h10000, 16'h0040); wr('h10000, 16'h7777); wait_ready();
    wr('h10000, 16'h0020); wr('h10000, 16'h00D0);
    repeat (5) @(negedge clk);
    m0 = mod_ops;
    wr(0, 16'h00B0);
    chk("R6 ready after erase suspend", ready_n_busy, 1);
    rd(0, d);
    chk("R6 erase suspend status", d, 16'h00C0);
    wr(0, 16'h00FF);
    rd('h10000, d);
    chk("R8 FFh ignored in erase suspend", d, 16'h00C0);
    wr(0, 16'h0090);
    rd(0, d);
    chk("R8 90h ignored in erase suspend", d, 16'h00C0);
    repeat (30) @(negedge clk);
    chk("R6 no array activity while suspended", mod_ops - m0, 0);
    chk("R6 still ready", ready_n_busy, 1);
    wr(0, 16'h00D0);
    chk("R7 busy after resume", ready_n_busy, 0);
    rd(0, d);
    chk("R7 resume clears suspend bit", d, 16'h0000);
    wait_ready();
    wr(0, 16'h00FF);
    rd('h10000, d);
    chk("R7 resumed erase completed", d, 16'hFFFF);
    chk("R7 single erase issued", mod_ops - m0, 1);
  endtask

  task automatic t_prog_susp();
    logic [DW-1:0] d;
    wr('h20000, 16'h0040); wr('h20000, 16'h1357);
    repeat (2) @(negedge clk);
    wr(0, 16'h00B0);
    rd(0, d);
    chk("R6 program suspend status", d, 16'h0084);
    wr(0, 16'h00FF);
    rd('h08000, d);
    chk("R9 array read in program suspend", d, 16'h2222);
    rd('h20000, d);
    chk("R9 word not yet programmed", d, 16'hFFFF);
    wr(0, 16'h00D0);
    wait_ready();
    wr(0, 16'h00FF);
    rd('h20000, d);
    chk("R7 resumed program completed", d, 16'h1357);
  endtask

  task automatic t_lock();
    logic [DW-1:0] d;
    int m0;
    wp_n = 1;
    wr('h3E010, 16'h0040); wr('h3E010, 16'h00FF); wait_ready();
    wp_n = 0;
    m0 = mod_ops;
    wr('h3F000, 16'h0040); wr('h3F000, 16'h0000);
    chk("R10 locked program stays ready", ready_n_busy, 1);
    rd(0, d);
    chk("R10 locked program error", d, 16'h0090);
    wr(0, 16'h0050);
    wr('h3E010, 16'h0020); wr('h3E010, 16'h00D0);
    rd(0, d);
    chk("R10 locked erase error", d, 16'h00A0);
    chk("R10 no array change request", mod_ops - m0, 0);
    wr(0, 16'h00FF);
    rd('h3E010, d); chk("R10 boot word preserved", d, 16'h00FF);
    rd('h3F000, d); chk("R10 boot word unprogrammed", d, 16'hFFFF);
    wr(0, 16'h0050);
    wr('h3D000, 16'h0040); wr('h3D000, 16'h0F0F); wait_ready();
    wr(0, 16'h00FF);
    rd('h3D000, d); chk("R10 unlocked block programs", d, 16'h0F0F);
    wp_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_ident();
    t_program();
    t_erase();
    t_bad_confirm();
    t_erase_susp();
    t_prog_susp();
    t_lock();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule